// File: doc/BRIEF.md
# Periodic Reload Down-Counter Timer

This block is a small timer peripheral sitting on a plain word-wide register port. A free-running divider turns the system clock into a fixed-rate tick enable (1 MHz when the divide ratio matches the system clock). A down-counter steps once per tick while running and refills from a programmable period value when it passes zero. Nothing else happens on that refill: there is no interrupt line and no status flag. Software only polls the live count.

Three word registers are decoded inside a 256-byte window:
- a control word, with a self-clearing soft-reset bit and a start bit;
- the period (reload) value;
- the live count.

Starting the counter is sticky. Once running, it keeps counting until a soft reset or a hardware reset, even if a later control write has the start bit clear. Writing the period also loads the counter at once. Typical use: software writes a period, sets the start bit, and later reads the count to measure elapsed time modulo the period.

Top module: `reload_tick_timer`

## Requirements
- R1: After hardware reset (`rst_n` low), the control word, period and count all read 0, and the counter is stopped.
- R2: A write to offset 0x00 with bit 0 set clears the control word, the period, the count and the tick divider phase, and stops the counter. No other bit of that write is stored.
- R3: A write to offset 0x00 with bit 0 clear stores all 32 bits. A read of offset 0x00 returns the last stored word.
- R4: A control write with bit 0 clear and bit 1 set starts the counter. The running state takes effect on the clock edge of that write. While running, the count drops by one on each tick enable and holds between ticks.
- R5: A control write with bit 1 clear (and bit 0 clear) does not stop a running counter.
- R6: A write to offset 0x08 keeps bits 15:0 as the period and loads them into the count on the same edge. This load takes precedence over a coincident tick. A read of offset 0x08 returns the period zero-extended.
- R7: On a running tick with the count at 0, the count is refilled from the period. With a period of 0, the count stays at 0.
- R8: A read of offset 0x0C returns the live 16-bit count with bits 31:16 zero. Writes to offset 0x0C change nothing.
- R9: A tick enable occurs once every TICK_DIV system clocks. The divider phase restarts from zero at hardware or soft reset, so the first tick comes on the TICK_DIV-th rising edge after the reset edge.
- R10: Reads of any other offset, including non-word-aligned ones, return 0. Writes to them change no state.
- R11: `bus_rdata` is 0 in any cycle where `bus_rd` is low. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_rd | input | 1 | Read strobe; data is returned combinationally in the same cycle |
| bus_rdata | output | 32 | Read data |

## Verification
The counter is run with a non-zero period long enough to wrap several times, which separates correct refill-at-zero from free wrap to 0xFFFF. Period writes are issued at each of the four divider phases, so one of them lands on a tick edge and shows whether the load beats the decrement. A zero period exposes any underflow past zero. A start-bit-clear control write during counting, and a soft-reset write with every bit set, separate "stop on disable" and "store the reset word" faults from the intended behaviour. Writes to the count offset, to unmapped offsets and to misaligned offsets, followed by reads of every register, show that no state leaks. A cycle-accurate reference model compares the read data on every clock.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

   typedef enum logic [1:0] {
      RSEL_CTRL   = 2'd0,
      RSEL_PERIOD = 2'd1,
      RSEL_COUNT  = 2'd2,
      RSEL_NONE   = 2'd3
   } rtt_sel_e;

   localparam logic [7:0] OFS_CTRL   = 8'h00;
   localparam logic [7:0] OFS_PERIOD = 8'h08;
   localparam logic [7:0] OFS_COUNT  = 8'h0C;

   typedef struct packed {
      logic clr;    // soft reset of the whole block
      logic load;   // period written: load count now
      logic run;    // counter running
   } rtt_cmd_t;

   function automatic rtt_sel_e rtt_decode(input logic [7:0] ofs);
      rtt_sel_e s;
      case (ofs)
         OFS_CTRL:   s = RSEL_CTRL;
         OFS_PERIOD: s = RSEL_PERIOD;
         OFS_COUNT:  s = RSEL_COUNT;
         default:    s = RSEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
   parameter int unsigned TICK_DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

   if (TICK_DIV < 1) begin : g_bad_div
      $error("rtt_prescaler: TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_div1
      // Every clock is a tick; during a soft-reset cycle the tick is moot.
      assign tick = ~clr;
   end else begin : g_divn
      logic [PW-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            phase_q <= '0;
         end else if (clr || phase_q == LAST) begin
            phase_q <= '0;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end

      assign tick = (phase_q == LAST);

      assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick)
         else $error("tick enable asserted on two consecutive clocks");

      assert_clr_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> !tick)
         else $error("tick right after divider restart");
   end

endmodule

// File: rtl/rtt_regbank.sv
module rtt_regbank
   import rtt_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned RST_BIT = 0,
   parameter int unsigned EN_BIT  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       addr,
   input  logic [31:0]      wdata,
   input  logic             wr,
   input  logic             rd,
   input  logic [CNT_W-1:0] count,
   output logic [31:0]      rdata,
   output rtt_cmd_t         cmd,
   output logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] period
);
   rtt_sel_e         sel;
   logic [31:0]      ctrl_q;
   logic [CNT_W-1:0] period_q;
   logic             run_q;
   logic             wr_ctrl, wr_period, soft_rst;

   assign sel       = rtt_decode(addr);
   assign wr_ctrl   = wr && (sel == RSEL_CTRL);
   assign wr_period = wr && (sel == RSEL_PERIOD);
   assign soft_rst  = wr_ctrl && wdata[RST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         period_q <= '0;
         run_q    <= 1'b0;
      end else if (soft_rst) begin
         ctrl_q   <= '0;
         period_q <= '0;
         run_q    <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q <= wdata;
            if (wdata[EN_BIT]) run_q <= 1'b1;
         end
         if (wr_period) period_q <= wdata[CNT_W-1:0];
      end
   end

   assign cmd.clr  = soft_rst;
   assign cmd.load = wr_period;
   assign cmd.run  = run_q;
   assign load_val = wdata[CNT_W-1:0];
   assign period   = period_q;

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (sel)
            RSEL_CTRL:   rdata = ctrl_q;
            RSEL_PERIOD: rdata = 32'(period_q);
            RSEL_COUNT:  rdata = 32'(count);
            default:     rdata = '0;
         endcase
      end
   end

   assert_soft_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctrl_q == '0) && (period_q == '0) && !run_q)
      else $error("soft reset left state behind");

   assert_ctrl_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wdata[RST_BIT]) |=> ctrl_q == $past(wdata))
      else $error("control word not stored");

   assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wdata[RST_BIT] && wdata[EN_BIT]) |=> run_q)
      else $error("start bit did not start counter");

   assert_run_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !soft_rst) |=> run_q)
      else $error("counter stopped without reset");

   assert_no_stray_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && (sel == RSEL_CTRL || sel == RSEL_PERIOD)) |=> $stable(ctrl_q) && $stable(period_q))
      else $error("state changed without a mapped write");

endmodule

// File: rtl/rtt_counter.sv
module rtt_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step = tick && run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (step) begin
         cnt_q <= (cnt_q == '0) ? period : cnt_q - 1'b1;
      end
   end

   assign count = cnt_q;

   assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1)
      else $error("count did not decrement on tick");

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr && !load) |=> $stable(cnt_q))
      else $error("count moved without tick");

   assert_refill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !load && cnt_q == '0) |=> cnt_q == $past(period))
      else $error("count not refilled at zero");

   assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> cnt_q == $past(load_val))
      else $error("period write did not load count");

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt_q == '0)
      else $error("soft reset did not clear count");

endmodule

// File: rtl/reload_tick_timer.sv
module reload_tick_timer
   import rtt_pkg::*;
#(
   parameter int unsigned TICK_DIV = 50,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned RST_BIT  = 0,
   parameter int unsigned EN_BIT   = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   input  logic        bus_wr,
   input  logic        bus_rd,
   output logic [31:0] bus_rdata
);
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
      $error("reload_tick_timer: CNT_W must be 1..32");
   end
   if (RST_BIT > 31 || EN_BIT > 31 || RST_BIT == EN_BIT) begin : g_bad_bits
      $error("reload_tick_timer: control bit positions invalid");
   end

   rtt_cmd_t         cmd;
   logic             tick;
   logic [CNT_W-1:0] count, load_val, period;

   rtt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cmd.clr),
      .tick  (tick)
   );

   rtt_regbank #(.CNT_W(CNT_W), .RST_BIT(RST_BIT), .EN_BIT(EN_BIT)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .wr       (bus_wr),
      .rd       (bus_rd),
      .count    (count),
      .rdata    (bus_rdata),
      .cmd      (cmd),
      .load_val (load_val),
      .period   (period)
   );

   rtt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .clr      (cmd.clr),
      .load     (cmd.load),
      .load_val (load_val),
      .run      (cmd.run),
      .period   (period),
      .count    (count)
   );

   assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0)
      else $error("read data driven without read strobe");

   assert_count_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFS_COUNT) |-> bus_rdata[31:CNT_W-1] == 32'(count) >> (CNT_W-1))
      else $error("count read upper bits not zero");

endmodule

// File: tb/reload_tick_timer_test.sv
module reload_tick_timer_test;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // reference model state
   int          m_pre = 0;
   bit          m_run = 1'b0;
   logic [31:0] m_ctrl = '0;
   logic [15:0] m_per = '0;
   logic [15:0] m_cnt = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   reload_tick_timer #(.TICK_DIV(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0; m_run = 0; m_ctrl = '0; m_per = '0; m_cnt = '0;
      end else begin
         bit tick_now;
         bit run_old;
         tick_now = (m_pre == DIV - 1);
         run_old  = m_run;
         m_pre    = tick_now ? 0 : m_pre + 1;
         if (bus_wr && bus_addr == 8'h00 && bus_wdata[0]) begin
            m_pre = 0; m_run = 0; m_ctrl = '0; m_per = '0; m_cnt = '0;
         end else begin
            if (bus_wr && bus_addr == 8'h00) begin
               m_ctrl = bus_wdata;
               if (bus_wdata[1]) m_run = 1;
            end
            if (bus_wr && bus_addr == 8'h08) begin
               m_per = bus_wdata[15:0];
               m_cnt = bus_wdata[15:0];
            end else if (tick_now && run_old) begin
               m_cnt = (m_cnt == 0) ? m_per : m_cnt - 16'd1;
            end
         end
      end
   end

   function automatic logic [31:0] model_read(input bit rd, input logic [7:0] a);
      if (!rd) return '0;
      case (a)
         8'h00:   return m_ctrl;
         8'h08:   return {16'h0, m_per};
         8'h0C:   return {16'h0, m_cnt};
         default: return '0;
      endcase
   endfunction

   task automatic cycle(input bit wr, input bit rd, input logic [7:0] a,
                        input logic [31:0] d, input string tag);
      logic [31:0] exp;
      @(negedge clk);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      #1;
      exp = model_read(rd, a);
      vectors++;
      if (bus_rdata !== exp) begin
         miscompares++;
         $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cycle(1'b0, 1'b1, 8'h0C, '0, tag);
   endtask

   task automatic read_all(input string tag);
      cycle(1'b0, 1'b1, 8'h00, '0, tag);
      cycle(1'b0, 1'b1, 8'h08, '0, tag);
      cycle(1'b0, 1'b1, 8'h0C, '0, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      read_all("R1");
      idle(3 * DIV, "R1");
      // R3: store full control word without start
      cycle(1'b1, 1'b1, 8'h00, 32'hA5A5_0000, "R3");
      read_all("R3");
      // R6: period keeps low 16 bits and loads count
      cycle(1'b1, 1'b1, 8'h08, 32'hDEAD_0007, "R6");
      read_all("R6");
      idle(2 * DIV, "R6");
      // R4 / R7: start, count down and refill several times
      cycle(1'b1, 1'b1, 8'h00, 32'h0000_0002, "R4");
      idle(20 * DIV, "R7");
      // R5: start bit cleared, still counting
      cycle(1'b1, 1'b1, 8'h00, 32'h1234_5678, "R5");
      idle(10 * DIV, "R5");
      // R8: writes to count offset ignored
      cycle(1'b1, 1'b1, 8'h0C, 32'hFFFF_1234, "R8");
      read_all("R8");
      // R10: unmapped and misaligned offsets
      cycle(1'b1, 1'b1, 8'h04, 32'hFFFF_FFFF, "R10");
      cycle(1'b1, 1'b1, 8'h10, 32'hFFFF_FFFF, "R10");
      cycle(1'b1, 1'b1, 8'hFC, 32'hFFFF_FFFF, "R10");
      cycle(1'b1, 1'b1, 8'h09, 32'hFFFF_FFFF, "R10");
      cycle(1'b1, 1'b1, 8'h01, 32'hFFFF_FFFF, "R10");
      cycle(1'b0, 1'b1, 8'h0D, '0, "R10");
      read_all("R10");
      // R11: no read strobe
      for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0, 8'h00, '0, "R11");
      cycle(1'b0, 1'b0, 8'h08, '0, "R11");
      read_all("R11");
      // R6: period writes at every divider phase, one coincides with tick
      for (int p = 0; p < DIV; p++) begin
         cycle(1'b1, 1'b1, 8'h08, 32'h0000_0005 + p, "R6");
         idle(DIV + p, "R6");
      end
      // R7: zero period holds zero
      cycle(1'b1, 1'b1, 8'h08, 32'hFFFF_0000, "R7");
      idle(8 * DIV, "R7");
      // R2: soft reset with every bit set
      cycle(1'b1, 1'b1, 8'h08, 32'h0000_0009, "R2");
      idle(DIV + 1, "R2");
      cycle(1'b1, 1'b1, 8'h00, 32'hFFFF_FFFF, "R2");
      read_all("R2");
      idle(4 * DIV, "R2");
      // R9: tick phase after soft reset, restart with short period
      cycle(1'b1, 1'b1, 8'h08, 32'h0000_0003, "R9");
      cycle(1'b1, 1'b1, 8'h00, 32'h0000_0002, "R9");
      idle(12 * DIV, "R9");
      cycle(1'b1, 1'b1, 8'h00, 32'h0000_0001, "R9");
      cycle(1'b1, 1'b1, 8'h08, 32'h0000_0002, "R9");
      cycle(1'b1, 1'b1, 8'h00, 32'h0000_0002, "R9");
      idle(6 * DIV, "R9");
      // R1: hardware reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      read_all("R1");
      idle(2 * DIV, "R1");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL R4 watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule